// File: doc/BRIEF.md
# Timestamp Capture Unit with Two-Entry FIFOs

This block records when events happen on three external input pins. A shared 16-bit timebase count comes in from outside. When a qualified transition of the selected kind appears on a channel's pin, that channel stores the count value in its own two-entry FIFO and raises an event flag. Each pin is first synchronized to the clock. A change is accepted only after the new level has been stable for two clock edges, so single-cycle glitches never produce a timestamp.

Software uses a small register port to work the block. It sets the edge selection and interrupt masks for each channel and reads a status word that holds a 2-bit fill code per channel. Each read of a channel's data address returns the oldest timestamp and removes it from the FIFO. Software can also force the fill codes, for example to empty every FIFO at once. The interrupt flags are cleared by writing ones to them. When a capture arrives at a full FIFO, the oldest entry is dropped and the fill code shows an overrun.

Top module: `cap_stamp_unit`

## Requirements
- R1: After reset, the control word (address 0), the status word (address 1), the flag word (address 2) and `irq` all read zero.
- R2: A pin change counts only once the new level has been held across two clock edges, so a one-cycle pulse produces no capture. A change first sampled at clock edge k is stored at edge k+4, with the count value present at that edge.
- R3: Control bits [2c+1:2c] select the edge for channel c: 00 off, 01 rising, 10 falling, 11 both.
- R4: Reading address 4+c returns channel c's oldest stored timestamp and removes it. Entries come out in the order they were captured.
- R5: Status bits [2c+1:2c] give channel c's fill code: 00 empty, 01 one entry, 10 two entries, 11 captured while full. The code stays unchanged when nothing acts on that FIFO.
- R6: A capture into a FIFO holding two entries drops the oldest entry, keeps the two newest and sets the code to 11. A following read returns the second-oldest entry and leaves code 01.
- R7: A read and a capture on the same channel in the same cycle leave the fill code unchanged. The read returns the previous oldest entry.
- R8: A capture sets flag bit c (address 2, bits [c], also mirrored read-only in status bits [8+c]). Writing 1 to a flag bit clears it. `irq[c]` is flag c AND mask bit, where the mask is control bit [8+c].
- R9: Writing the status word forces every channel's fill code to the written bits [2c+1:2c]. Writes to the flag mirror bits are ignored.
- R10: Reading an empty channel's FIFO leaves its fill code at 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cap_pin | input | 3 | Capture input pins, one per channel |
| tb_count | input | 16 | Shared timebase count to be stamped |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops a FIFO at a data address) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from address |
| irq | output | 3 | Masked per-channel interrupt requests |

## Verification
If the qualifier holds a wrong level, the fill code and flag show it about four cycles after a pin change. They show a missing capture, an extra capture, or a capture of the opposite edge. A FIFO pointer or fill code that goes wrong shows up at the very next data read. The read returns a timestamp that does not match the count the bench drove at the capture edge, or the code is wrong when the status word is next read. The bench drives the count as a free-running ramp, so every stored value names exactly the cycle in which it was taken.

// File: rtl/cap_pkg.sv
`timescale 1ns/1ps
package cap_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef enum logic [1:0] {
    FILL_EMPTY = 2'b00,
    FILL_ONE   = 2'b01,
    FILL_TWO   = 2'b10,
    FILL_OVER  = 2'b11
  } fill_code_e;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_STAT = 1;
  localparam int ADDR_FLAG = 2;
  localparam int ADDR_FIFO = 4;
  localparam int MASK_LSB  = 8;
  localparam int MIRR_LSB  = 8;
endpackage

// File: rtl/cap_rst_sync.sv
`timescale 1ns/1ps
module cap_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/cap_in_qual.sv
`timescale 1ns/1ps
module cap_in_qual
  import cap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] edge_sel,
  output logic       cap_evt
);
  logic sync1_q, sync2_q, hold0_q, hold1_q, lvl_q;
  logic lvl_d;
  logic settled;
  logic rise, fall;

  always_comb begin
    settled = (hold0_q == hold1_q) && (hold1_q != lvl_q);
    rise    = settled && hold1_q;
    fall    = settled && !hold1_q;
    lvl_d   = settled ? hold1_q : lvl_q;
    cap_evt = (rise && edge_sel[0]) || (fall && edge_sel[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      hold0_q <= 1'b0;
      hold1_q <= 1'b0;
      lvl_q   <= 1'b0;
    end else begin
      sync1_q <= pin;
      sync2_q <= sync1_q;
      hold0_q <= sync2_q;
      hold1_q <= hold0_q;
      lvl_q   <= lvl_d;
    end
  end
endmodule

// File: rtl/cap_fifo2.sv
`timescale 1ns/1ps
module cap_fifo2
  import cap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_evt,
  input  logic [CNT_W-1:0] ts_in,
  input  logic             pop,
  input  logic             st_wr,
  input  logic [1:0]       st_wdata,
  output logic [CNT_W-1:0] head,
  output logic [1:0]       status
);
  logic [CNT_W-1:0] ent0_q, ent1_q, ent0_d, ent1_d;
  logic             ent_en;
  logic [1:0]       st_q, st_d;
  logic [1:0]       fill;
  logic             do_pop;

  always_comb begin
    case (st_q)
      FILL_EMPTY: fill = 2'd0;
      FILL_ONE:   fill = 2'd1;
      default:    fill = 2'd2;
    endcase
    do_pop = pop && (fill != 2'd0);
    ent0_d = ent0_q;
    ent1_d = ent1_q;
    st_d   = st_q;
    if (st_wr) begin
      st_d = st_wdata;
    end else begin
      case ({cap_evt, do_pop})
        2'b10: begin
          case (fill)
            2'd0: begin ent0_d = ts_in; st_d = FILL_ONE; end
            2'd1: begin ent1_d = ts_in; st_d = FILL_TWO; end
            default: begin ent0_d = ent1_q; ent1_d = ts_in; st_d = FILL_OVER; end
          endcase
        end
        2'b01: begin
          ent0_d = ent1_q;
          st_d   = (fill == 2'd1) ? FILL_EMPTY : FILL_ONE;
        end
        2'b11: begin
          if (fill == 2'd1) begin
            ent0_d = ts_in;
          end else begin
            ent0_d = ent1_q;
            ent1_d = ts_in;
          end
        end
        default: ;
      endcase
    end
    ent_en = !st_wr && (cap_evt || do_pop);
  end

  always_ff @(posedge clk) begin
    if (ent_en) begin
      ent0_q <= ent0_d;
      ent1_q <= ent1_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= FILL_EMPTY;
    else        st_q <= st_d;
  end

  assign head   = ent0_q;
  assign status = st_q;
endmodule

// File: rtl/cap_stamp_unit.sv
`timescale 1ns/1ps
module cap_stamp_unit
  import cap_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] cap_pin,
  input  logic [CNT_W-1:0]  tb_count,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int SEL_W = 2 * NUM_CH;

  logic                rst_sync_n;
  logic [SEL_W-1:0]    sel_q, sel_d;
  logic [NUM_CH-1:0]   mask_q, mask_d;
  logic [NUM_CH-1:0]   flag_q, flag_d;
  logic [NUM_CH-1:0]   cap_evt;
  logic [NUM_CH-1:0]   pop_vec;
  logic [SEL_W-1:0]    st_flat;
  logic                st_wr;
  logic                ctrl_wr;
  logic                flag_wr;
  logic [CNT_W-1:0]    head [NUM_CH];
  logic                unused_bits;

  cap_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign ctrl_wr     = reg_wr && (reg_addr == ADDR_W'(ADDR_CTRL));
  assign st_wr       = reg_wr && (reg_addr == ADDR_W'(ADDR_STAT));
  assign flag_wr     = reg_wr && (reg_addr == ADDR_W'(ADDR_FLAG));
  assign unused_bits = ^reg_wdata;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign pop_vec[c] = reg_rd && (reg_addr == ADDR_W'(ADDR_FIFO + c));

      cap_in_qual u_qual (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .pin      (cap_pin[c]),
        .edge_sel (sel_q[2*c +: 2]),
        .cap_evt  (cap_evt[c])
      );

      cap_fifo2 #(.CNT_W(CNT_W)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .cap_evt  (cap_evt[c]),
        .ts_in    (tb_count),
        .pop      (pop_vec[c]),
        .st_wr    (st_wr),
        .st_wdata (reg_wdata[2*c +: 2]),
        .head     (head[c]),
        .status   (st_flat[2*c +: 2])
      );
    end
  endgenerate

  always_comb begin
    sel_d  = ctrl_wr ? reg_wdata[SEL_W-1:0] : sel_q;
    mask_d = ctrl_wr ? reg_wdata[MASK_LSB +: NUM_CH] : mask_q;
    flag_d = (flag_q & ~(flag_wr ? reg_wdata[NUM_CH-1:0] : '0)) | cap_evt;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sel_q  <= '0;
      mask_q <= '0;
      flag_q <= '0;
    end else begin
      sel_q  <= sel_d;
      mask_q <= mask_d;
      flag_q <= flag_d;
    end
  end

  assign irq = flag_q & mask_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(ADDR_CTRL)) begin
      reg_rdata[SEL_W-1:0]          = sel_q;
      reg_rdata[MASK_LSB +: NUM_CH] = mask_q;
    end else if (reg_addr == ADDR_W'(ADDR_STAT)) begin
      reg_rdata[SEL_W-1:0]          = st_flat;
      reg_rdata[MIRR_LSB +: NUM_CH] = flag_q;
    end else if (reg_addr == ADDR_W'(ADDR_FLAG)) begin
      reg_rdata[NUM_CH-1:0] = flag_q;
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_addr == ADDR_W'(ADDR_FIFO + c)) reg_rdata = head[c];
    end
  end
endmodule

// File: rtl/cap_stamp_chk.sv
`timescale 1ns/1ps
module cap_stamp_chk #(
  parameter int NUM_CH = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_CH-1:0]   cap_evt,
  input logic [NUM_CH-1:0]   pop,
  input logic                st_wr,
  input logic [2*NUM_CH-1:0] status,
  input logic [NUM_CH-1:0]   flags,
  input logic [2*NUM_CH-1:0] edge_sel
);
  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_a
      assert_flag_on_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt[c] |=> flags[c]);
      assert_off_no_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel[2*c +: 2] == 2'b00) |-> !cap_evt[c]);
      assert_overrun_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt[c] && !pop[c] && !st_wr && status[2*c+1]) |=> (status[2*c +: 2] == 2'b11));
      assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_evt[c] && !pop[c] && !st_wr) |=> $stable(status[2*c +: 2]));
      assert_rd_cap_same_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt[c] && pop[c] && !st_wr && (status[2*c +: 2] != 2'b00)) |=> $stable(status[2*c +: 2]));
      assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop[c] && !cap_evt[c] && !st_wr && (status[2*c +: 2] == 2'b00)) |=> (status[2*c +: 2] == 2'b00));
    end
  endgenerate
endmodule

bind cap_stamp_unit cap_stamp_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cap_evt  (cap_evt),
  .pop      (pop_vec),
  .st_wr    (st_wr),
  .status   (st_flat),
  .flags    (flag_q),
  .edge_sel (sel_q)
);

// File: tb/cap_stamp_unit_tb.sv
`timescale 1ns/1ps
module cap_stamp_unit_tb;
  logic        clk;
  logic        rst_n;
  logic [2:0]  cap_pin;
  logic [15:0] tb_count;
  logic [2:0]  reg_addr;
  logic        reg_wr;
  logic        reg_rd;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [2:0]  irq;
  int n_chk;
  int n_err;

  cap_stamp_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .tb_count(tb_count),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) tb_count <= tb_count + 16'd1;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // Change a pin level; returns the count seen at the first sampling edge.
  task automatic set_pin(input int c, input logic v, output logic [15:0] cnt_at);
    @(negedge clk);
    cap_pin[c] = v;
    #1 cnt_at = tb_count;
    repeat (7) @(negedge clk);
  endtask

  initial begin
    #3000000;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] d, va, vb, vc;
    n_chk = 0; n_err = 0;
    cap_pin = '0; tb_count = '0; reg_addr = '0; reg_wr = 0; reg_rd = 0; reg_wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(3'd0, d); chk("R1 ctrl", d, 16'h0);
    rd(3'd1, d); chk("R1 status", d, 16'h0);
    rd(3'd2, d); chk("R1 flags", d, 16'h0);
    chk("R1 irq", {13'd0, irq}, 16'h0);

    // R3/R2/R4 sweep: every channel, every edge select, both directions
    for (int c = 0; c < 3; c++) begin
      for (int s = 0; s < 4; s++) begin
        wr(3'd0, 16'(s) << (2 * c));
        wr(3'd1, 16'h0);
        wr(3'd2, 16'h7);
        set_pin(c, 1'b1, va);
        rd(3'd1, d);
        chk($sformatf("R3 rise ch%0d sel%0d", c, s), d[5:0], 6'((s & 1) != 0) << (2 * c));
        if ((s & 1) != 0) begin
          rd(3'(4 + c), d); chk($sformatf("R2 R4 rise stamp ch%0d", c), d, va + 16'd4);
          rd(3'd1, d); chk("R4 popped", d[5:0], 6'h0);
        end
        set_pin(c, 1'b0, vb);
        rd(3'd1, d);
        chk($sformatf("R3 fall ch%0d sel%0d", c, s), d[5:0], 6'((s & 2) != 0) << (2 * c));
        if ((s & 2) != 0) begin
          rd(3'(4 + c), d); chk($sformatf("R2 R4 fall stamp ch%0d", c), d, vb + 16'd4);
        end
      end
    end

    // R2 glitch rejection and two-cycle pulse
    wr(3'd0, 16'h0003); wr(3'd1, 16'h0);
    @(negedge clk); cap_pin[0] = 1'b1;
    @(negedge clk); cap_pin[0] = 1'b0;
    repeat (8) @(negedge clk);
    rd(3'd1, d); chk("R2 one-cycle pulse ignored", d[5:0], 6'h0);
    @(negedge clk); cap_pin[0] = 1'b1; #1 va = tb_count;
    @(negedge clk);
    @(negedge clk); cap_pin[0] = 1'b0;
    repeat (8) @(negedge clk);
    rd(3'd1, d); chk("R2 two-cycle pulse both edges", d[5:0], 6'h2);
    rd(3'd4, d); chk("R2 pulse rise stamp", d, va + 16'd4);
    rd(3'd4, d); chk("R2 pulse fall stamp", d, va + 16'd6);

    // R8 flags, mirror and irq; R9 status force
    wr(3'd2, 16'h7); wr(3'd1, 16'h0);
    wr(3'd0, 16'h0200 | 16'h000C);
    rd(3'd0, d); chk("R8 ctrl readback", d, 16'h020C);
    set_pin(1, 1'b1, va);
    rd(3'd2, d); chk("R8 flag set", d, 16'h0002);
    chk("R8 irq masked on", {13'd0, irq}, 16'h0002);
    rd(3'd1, d); chk("R8 status mirror", d, 16'h0204);
    wr(3'd1, 16'h0700 | 16'h0008);
    rd(3'd1, d); chk("R9 forced code, mirror read-only", d, 16'h0208);
    wr(3'd2, 16'h0002);
    rd(3'd2, d); chk("R8 flag cleared", d, 16'h0);
    chk("R8 irq cleared", {13'd0, irq}, 16'h0);
    wr(3'd1, 16'h0);
    rd(3'd1, d); chk("R9 forced empty", d, 16'h0);

    // R6 overrun, R10 empty pop
    wr(3'd0, 16'h0030); wr(3'd1, 16'h0);
    set_pin(2, 1'b1, va);
    set_pin(2, 1'b0, vb);
    set_pin(2, 1'b1, vc);
    rd(3'd1, d); chk("R6 overrun code", d[5:0], 6'h30);
    rd(3'd6, d); chk("R6 oldest dropped", d, vb + 16'd4);
    rd(3'd1, d); chk("R6 after pop", d[5:0], 6'h10);
    rd(3'd6, d); chk("R6 newest", d, vc + 16'd4);
    rd(3'd1, d); chk("R6 empty", d[5:0], 6'h0);
    rd(3'd6, d);
    rd(3'd1, d); chk("R10 empty pop", d[5:0], 6'h0);
    set_pin(2, 1'b0, va);
    wr(3'd1, 16'h0);

    // R7 simultaneous read and capture
    wr(3'd0, 16'h0003);
    set_pin(0, 1'b1, va);
    @(negedge clk); cap_pin[0] = 1'b0; #1 vb = tb_count;
    repeat (4) @(negedge clk);
    reg_addr = 3'd4; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
    chk("R7 read returns old entry", d, va + 16'd4);
    rd(3'd1, d); chk("R7 code unchanged", d[5:0], 6'h1);
    rd(3'd4, d); chk("R7 new entry kept", d, vb + 16'd4);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule